// File: doc/BRIEF.md
# Video-mode line and frame packet scheduler

This block steps through one video frame at a time for a serial display link and, for every timing region it enters, hands a downstream packet builder a region code and a length. The vertical blanking and active regions carry their length as a number of lines. The horizontal regions inside each active line carry their length as a number of payload bytes. The byte counts are derived from pixel counts, the pixel format and fixed per-packet overhead deductions.

The timing values come from configuration inputs that a register file drives. They are captured at the start of each frame, so a frame is always built from one consistent set. A frame is launched by a rising edge on the start input. Frames then follow back to back for as long as start stays high. The sync-pulse mode input chooses whether a separate horizontal sync region is sent. The dual-link input halves the active width, for a link that carries only one half of each line.

Top module: `vid_timing_seq`

## Requirements
- R1: While reset is asserted and after its release, `tok_valid_o` is low and `tok_region_o` shows the front porch code 3.
- R2: Region codes are VSA=0, VBP=1, VACT=2, VFP=3, HSA=4, HBP=5, HACT=6, HFP=7. A frame is sent as VSA, VBP, VACT, then one line group per active line, then VFP. A line group is HSA, HBP, HACT, HFP in sync-pulse mode and HBP, HACT, HFP otherwise.
- R3: The VSA, VBP, VACT and VFP tokens carry the programmed line counts. When the active line count is 0, no line group is sent, and VFP follows VACT directly.
- R4: Bytes per pixel is 2 when `pix_fmt_i` is 0 (16-bit) and 3 for any other value, including 3 (packed 24-bit).
- R5: The HSA count is sync pixels times bytes per pixel, minus 10. The HFP count is front porch pixels times bytes per pixel, minus 12. Either count is 0 when the deduction exceeds the product.
- R6: In sync-pulse mode the HBP count is back porch pixels times bytes per pixel, minus 10. In the other mode it is (sync + back porch pixels) times bytes per pixel, minus 10, and no HSA token is sent. The HBP count is 0 when the deduction exceeds the product.
- R7: The HACT count is the active width times bytes per pixel, taken modulo 2^CNT_W. In dual-link mode the active width is first halved, rounding down.
- R8: While `tok_valid_o` is high and `tok_ready_i` is low, the valid, region and count outputs hold steady. A token is consumed only when valid and ready are both high.
- R9: A frame starts on a rising edge of `start_i`. When VFP is accepted with `start_i` high, the next frame begins with VSA at once. When VFP is accepted with `start_i` low, the block goes idle: valid low and region 3.
- R10: The configuration inputs are sampled when a frame starts. Changes made during a frame affect only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start bit: a rising edge launches a frame, holding it high repeats frames |
| sync_pulse_i | input | 1 | 1 sends a separate horizontal sync region |
| dual_link_i | input | 1 | 1 halves the active width |
| pix_fmt_i | input | 2 | Pixel format; 0 is 16-bit, 3 is packed 24-bit |
| vsa_lines_i | input | LINE_W | Vertical sync lines |
| vbp_lines_i | input | LINE_W | Vertical back porch lines |
| vact_lines_i | input | LINE_W | Active lines |
| vfp_lines_i | input | LINE_W | Vertical front porch lines |
| hsa_pix_i | input | PIX_W | Horizontal sync pixels |
| hbp_pix_i | input | PIX_W | Horizontal back porch pixels |
| hact_pix_i | input | PIX_W | Active pixels per line |
| hfp_pix_i | input | PIX_W | Horizontal front porch pixels |
| tok_valid_o | output | 1 | Token valid |
| tok_ready_i | input | 1 | Token accepted by the packet builder |
| tok_region_o | output | 3 | Region code |
| tok_count_o | output | CNT_W | Line count or byte count |

## Verification
The stimulus table covers both pixel formats, a non-zero format other than 3, both sync modes, and dual-link mode with an odd active width. These cases separate the multiplier choice, the merging of the sync width into the back porch, and the rounding of the halving. Further rows bring pixel counts below the overhead, to expose missing clamping, and an active width whose byte count overflows the count field, to expose missing truncation. A frame with zero active lines checks that the line loop can be skipped. Directed runs hold start high across two frames while changing the configuration mid-frame, and stall the ready input to show that tokens are held and not lost.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic [2:0] {
    RG_VSA  = 3'd0,
    RG_VBP  = 3'd1,
    RG_VACT = 3'd2,
    RG_VFP  = 3'd3,
    RG_HSA  = 3'd4,
    RG_HBP  = 3'd5,
    RG_HACT = 3'd6,
    RG_HFP  = 3'd7
  } region_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VSA,
    ST_VBP,
    ST_VACT,
    ST_HSA,
    ST_HBP,
    ST_HACT,
    ST_HFP,
    ST_VFP
  } state_e;

  localparam int unsigned SYNC_OVH  = 10;
  localparam int unsigned BPORCH_OVH = 10;
  localparam int unsigned FPORCH_OVH = 12;
  localparam logic [1:0]  FMT_16B   = 2'd0;

endpackage

// File: rtl/vts_byte_calc.sv
module vts_byte_calc #(
  parameter int unsigned PIX_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic [1:0]       pix_fmt_i,
  input  logic             sync_pulse_i,
  input  logic             dual_link_i,
  input  logic [PIX_W-1:0] hsa_pix_i,
  input  logic [PIX_W-1:0] hbp_pix_i,
  input  logic [PIX_W-1:0] hact_pix_i,
  input  logic [PIX_W-1:0] hfp_pix_i,
  output logic [CNT_W-1:0] hsa_byte_o,
  output logic [CNT_W-1:0] hbp_byte_o,
  output logic [CNT_W-1:0] hact_byte_o,
  output logic [CNT_W-1:0] hfp_byte_o
);
  import vts_pkg::*;

  // product width: (sum of two PIX_W values) * 3
  localparam int unsigned PW = PIX_W + 3;

  logic [PW-1:0]    bpp;
  logic [PIX_W:0]   hbp_eff;
  logic [PIX_W-1:0] hact_eff;
  logic [PW-1:0]    hsa_prod, hbp_prod, hact_prod, hfp_prod;

  function automatic logic [CNT_W-1:0] ovh_sub(input logic [PW-1:0] prod,
                                                input logic [PW-1:0] ovh);
    logic [PW-1:0] diff;
    diff = prod - ovh;
    return (prod < ovh) ? '0 : diff[CNT_W-1:0];
  endfunction

  always_comb begin
    bpp       = (pix_fmt_i == FMT_16B) ? PW'(2) : PW'(3);
    // without a sync pulse the sync width is folded into back porch
    hbp_eff   = sync_pulse_i ? {1'b0, hbp_pix_i}
                             : ({1'b0, hsa_pix_i} + {1'b0, hbp_pix_i});
    hact_eff  = dual_link_i ? (hact_pix_i >> 1) : hact_pix_i;
    hsa_prod  = PW'(hsa_pix_i) * bpp;
    hbp_prod  = PW'(hbp_eff) * bpp;
    hact_prod = PW'(hact_eff) * bpp;
    hfp_prod  = PW'(hfp_pix_i) * bpp;
  end

  assign hsa_byte_o  = ovh_sub(hsa_prod, PW'(SYNC_OVH));
  assign hbp_byte_o  = ovh_sub(hbp_prod, PW'(BPORCH_OVH));
  assign hfp_byte_o  = ovh_sub(hfp_prod, PW'(FPORCH_OVH));
  assign hact_byte_o = hact_prod[CNT_W-1:0];

endmodule

// File: rtl/vts_shadow.sv
module vts_shadow #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sync_pulse_i,
  input  logic [LINE_W-1:0] vsa_i,
  input  logic [LINE_W-1:0] vbp_i,
  input  logic [LINE_W-1:0] vact_i,
  input  logic [LINE_W-1:0] vfp_i,
  input  logic [CNT_W-1:0]  hsa_i,
  input  logic [CNT_W-1:0]  hbp_i,
  input  logic [CNT_W-1:0]  hact_i,
  input  logic [CNT_W-1:0]  hfp_i,
  output logic              sync_pulse_o,
  output logic [LINE_W-1:0] vsa_o,
  output logic [LINE_W-1:0] vbp_o,
  output logic [LINE_W-1:0] vact_o,
  output logic [LINE_W-1:0] vfp_o,
  output logic [CNT_W-1:0]  hsa_o,
  output logic [CNT_W-1:0]  hbp_o,
  output logic [CNT_W-1:0]  hact_o,
  output logic [CNT_W-1:0]  hfp_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_pulse_o <= 1'b0;
      vsa_o  <= '0;
      vbp_o  <= '0;
      vact_o <= '0;
      vfp_o  <= '0;
      hsa_o  <= '0;
      hbp_o  <= '0;
      hact_o <= '0;
      hfp_o  <= '0;
    end else if (load_i) begin
      sync_pulse_o <= sync_pulse_i;
      vsa_o  <= vsa_i;
      vbp_o  <= vbp_i;
      vact_o <= vact_i;
      vfp_o  <= vfp_i;
      hsa_o  <= hsa_i;
      hbp_o  <= hbp_i;
      hact_o <= hact_i;
      hfp_o  <= hfp_i;
    end
  end

endmodule

// File: rtl/vts_walker.sv
module vts_walker #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sync_pulse_i,
  input  logic [LINE_W-1:0] vsa_i,
  input  logic [LINE_W-1:0] vbp_i,
  input  logic [LINE_W-1:0] vact_i,
  input  logic [LINE_W-1:0] vfp_i,
  input  logic [CNT_W-1:0]  hsa_i,
  input  logic [CNT_W-1:0]  hbp_i,
  input  logic [CNT_W-1:0]  hact_i,
  input  logic [CNT_W-1:0]  hfp_i,
  output logic              load_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [2:0]        region_o,
  output logic [CNT_W-1:0]  count_o
);
  import vts_pkg::*;

  state_e            state_q, state_d;
  logic              start_q;
  logic [LINE_W-1:0] lines_left_q;
  logic              accept, start_rise;
  state_e            line_first;
  region_e           region;

  assign accept     = valid_o && ready_i;
  assign start_rise = start_i && !start_q;
  assign line_first = sync_pulse_i ? ST_HSA : ST_HBP;
  assign load_o     = ((state_q == ST_IDLE) && start_rise) ||
                      ((state_q == ST_VFP) && accept && start_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_rise) state_d = ST_VSA;
      ST_VSA:  if (accept) state_d = ST_VBP;
      ST_VBP:  if (accept) state_d = ST_VACT;
      ST_VACT: if (accept) state_d = (vact_i == '0) ? ST_VFP : line_first;
      ST_HSA:  if (accept) state_d = ST_HBP;
      ST_HBP:  if (accept) state_d = ST_HACT;
      ST_HACT: if (accept) state_d = ST_HFP;
      ST_HFP:  if (accept) state_d = (lines_left_q == LINE_W'(1)) ? ST_VFP : line_first;
      ST_VFP:  if (accept) state_d = start_i ? ST_VSA : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      start_q      <= 1'b0;
      lines_left_q <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
      if (state_q == ST_VACT && accept)
        lines_left_q <= vact_i;
      else if (state_q == ST_HFP && accept)
        lines_left_q <= lines_left_q - LINE_W'(1);
    end
  end

  always_comb begin
    valid_o = 1'b1;
    region  = RG_VFP;
    count_o = '0;
    unique case (state_q)
      ST_IDLE: valid_o = 1'b0;
      ST_VSA:  begin region = RG_VSA;  count_o = CNT_W'(vsa_i);  end
      ST_VBP:  begin region = RG_VBP;  count_o = CNT_W'(vbp_i);  end
      ST_VACT: begin region = RG_VACT; count_o = CNT_W'(vact_i); end
      ST_HSA:  begin region = RG_HSA;  count_o = hsa_i;  end
      ST_HBP:  begin region = RG_HBP;  count_o = hbp_i;  end
      ST_HACT: begin region = RG_HACT; count_o = hact_i; end
      ST_HFP:  begin region = RG_HFP;  count_o = hfp_i;  end
      ST_VFP:  begin region = RG_VFP;  count_o = CNT_W'(vfp_i); end
      default: valid_o = 1'b0;
    endcase
  end

  assign region_o = region;

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(region_o) && $stable(count_o));

  // R9
  idle_after_vfp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && region_o != 3'(RG_VFP) |=> valid_o);

  // R2
  vsa_then_vbp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && region_o == 3'(RG_VSA) |=> region_o == 3'(RG_VBP));

  // R3
  no_lines_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && region_o == 3'(RG_VACT) && vact_i == '0
    |=> region_o == 3'(RG_VFP));

  // R6
  hsa_pulse_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && region_o == 3'(RG_HSA) |-> sync_pulse_i);

endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned PIX_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sync_pulse_i,
  input  logic              dual_link_i,
  input  logic [1:0]        pix_fmt_i,
  input  logic [LINE_W-1:0] vsa_lines_i,
  input  logic [LINE_W-1:0] vbp_lines_i,
  input  logic [LINE_W-1:0] vact_lines_i,
  input  logic [LINE_W-1:0] vfp_lines_i,
  input  logic [PIX_W-1:0]  hsa_pix_i,
  input  logic [PIX_W-1:0]  hbp_pix_i,
  input  logic [PIX_W-1:0]  hact_pix_i,
  input  logic [PIX_W-1:0]  hfp_pix_i,
  output logic              tok_valid_o,
  input  logic              tok_ready_i,
  output logic [2:0]        tok_region_o,
  output logic [CNT_W-1:0]  tok_count_o
);

  logic [CNT_W-1:0]  hsa_b, hbp_b, hact_b, hfp_b;
  logic [CNT_W-1:0]  hsa_s, hbp_s, hact_s, hfp_s;
  logic [LINE_W-1:0] vsa_s, vbp_s, vact_s, vfp_s;
  logic              pulse_s, load;

  vts_byte_calc #(.PIX_W(PIX_W), .CNT_W(CNT_W)) i_calc (
    .pix_fmt_i    (pix_fmt_i),
    .sync_pulse_i (sync_pulse_i),
    .dual_link_i  (dual_link_i),
    .hsa_pix_i    (hsa_pix_i),
    .hbp_pix_i    (hbp_pix_i),
    .hact_pix_i   (hact_pix_i),
    .hfp_pix_i    (hfp_pix_i),
    .hsa_byte_o   (hsa_b),
    .hbp_byte_o   (hbp_b),
    .hact_byte_o  (hact_b),
    .hfp_byte_o   (hfp_b)
  );

  vts_shadow #(.LINE_W(LINE_W), .CNT_W(CNT_W)) i_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .sync_pulse_i (sync_pulse_i),
    .vsa_i        (vsa_lines_i),
    .vbp_i        (vbp_lines_i),
    .vact_i       (vact_lines_i),
    .vfp_i        (vfp_lines_i),
    .hsa_i        (hsa_b),
    .hbp_i        (hbp_b),
    .hact_i       (hact_b),
    .hfp_i        (hfp_b),
    .sync_pulse_o (pulse_s),
    .vsa_o        (vsa_s),
    .vbp_o        (vbp_s),
    .vact_o       (vact_s),
    .vfp_o        (vfp_s),
    .hsa_o        (hsa_s),
    .hbp_o        (hbp_s),
    .hact_o       (hact_s),
    .hfp_o        (hfp_s)
  );

  vts_walker #(.LINE_W(LINE_W), .CNT_W(CNT_W)) i_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .sync_pulse_i (pulse_s),
    .vsa_i        (vsa_s),
    .vbp_i        (vbp_s),
    .vact_i       (vact_s),
    .vfp_i        (vfp_s),
    .hsa_i        (hsa_s),
    .hbp_i        (hbp_s),
    .hact_i       (hact_s),
    .hfp_i        (hfp_s),
    .load_o       (load),
    .valid_o      (tok_valid_o),
    .ready_i      (tok_ready_i),
    .region_o     (tok_region_o),
    .count_o      (tok_count_o)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !tok_valid_o);

endmodule

// File: tb/test_vid_timing_seq.sv
module test_vid_timing_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 12;
  localparam int PIX_W  = 16;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic [1:0]  fmt;
    logic        pulse;
    logic        dual;
    logic [15:0] hsa, hbp, hact, hfp;
    logic [11:0] vsa, vbp, vact, vfp;
    logic [15:0] e_hsa, e_hbp, e_hact, e_hfp;
  } vec_t;

  // fmt pulse dual | hsa hbp hact hfp | vsa vbp vact vfp | expected hsa hbp hact hfp
  localparam vec_t VECS [8] = '{
    '{2'd3, 1'b1, 1'b0, 16'd10, 16'd20, 16'd100,   16'd30, 12'd2, 12'd3, 12'd2, 12'd4, 16'd20, 16'd50, 16'd300,   16'd78},
    '{2'd0, 1'b1, 1'b0, 16'd8,  16'd16, 16'd64,    16'd20, 12'd1, 12'd1, 12'd1, 12'd1, 16'd6,  16'd22, 16'd128,   16'd28}, // R4 16-bit
    '{2'd3, 1'b0, 1'b0, 16'd10, 16'd20, 16'd100,   16'd30, 12'd2, 12'd2, 12'd1, 12'd2, 16'd0,  16'd80, 16'd300,   16'd78}, // R6 no pulse
    '{2'd3, 1'b1, 1'b1, 16'd4,  16'd5,  16'd101,   16'd4,  12'd1, 12'd1, 12'd2, 12'd1, 16'd2,  16'd5,  16'd150,   16'd0},  // R7 dual, odd
    '{2'd0, 1'b1, 1'b0, 16'd3,  16'd1,  16'd1,     16'd5,  12'd1, 12'd1, 12'd1, 12'd1, 16'd0,  16'd0,  16'd2,     16'd0},  // R5 clamp
    '{2'd3, 1'b1, 1'b0, 16'd10, 16'd20, 16'd30000, 16'd30, 12'd1, 12'd1, 12'd1, 12'd1, 16'd20, 16'd50, 16'd24464, 16'd78}, // R7 wrap
    '{2'd0, 1'b1, 1'b0, 16'd8,  16'd16, 16'd64,    16'd20, 12'd1, 12'd2, 12'd0, 12'd3, 16'd6,  16'd22, 16'd128,   16'd28}, // R3 no lines
    '{2'd1, 1'b1, 1'b0, 16'd10, 16'd20, 16'd100,   16'd30, 12'd1, 12'd1, 12'd1, 12'd1, 16'd20, 16'd50, 16'd300,   16'd78}  // R4 other fmt
  };

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              start_i, sync_pulse_i, dual_link_i, tok_ready_i;
  logic [1:0]        pix_fmt_i;
  logic [LINE_W-1:0] vsa_lines_i, vbp_lines_i, vact_lines_i, vfp_lines_i;
  logic [PIX_W-1:0]  hsa_pix_i, hbp_pix_i, hact_pix_i, hfp_pix_i;
  logic              tok_valid_o;
  logic [2:0]        tok_region_o;
  logic [CNT_W-1:0]  tok_count_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vid_timing_seq #(.LINE_W(LINE_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) i_vid_timing_seq (
    .clk_i, .rst_ni, .start_i, .sync_pulse_i, .dual_link_i, .pix_fmt_i,
    .vsa_lines_i, .vbp_lines_i, .vact_lines_i, .vfp_lines_i,
    .hsa_pix_i, .hbp_pix_i, .hact_pix_i, .hfp_pix_i,
    .tok_valid_o, .tok_ready_i, .tok_region_o, .tok_count_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic apply(input vec_t v);
    pix_fmt_i    = v.fmt;
    sync_pulse_i = v.pulse;
    dual_link_i  = v.dual;
    hsa_pix_i    = v.hsa;
    hbp_pix_i    = v.hbp;
    hact_pix_i   = v.hact;
    hfp_pix_i    = v.hfp;
    vsa_lines_i  = v.vsa;
    vbp_lines_i  = v.vbp;
    vact_lines_i = v.vact;
    vfp_lines_i  = v.vfp;
  endtask

  // called at a negedge; consumes the token at the following posedge
  task automatic expect_tok(input logic [2:0] rg, input logic [15:0] cnt, input string req);
    int guard = 0;
    while (!tok_valid_o && guard < 200) begin
      @(negedge clk_i);
      guard++;
    end
    check(tok_valid_o && tok_region_o == rg, req, "region", tok_region_o, rg); // R2 order
    check(tok_count_o == cnt, req, "count", tok_count_o, cnt);
    @(negedge clk_i);
  endtask

  task automatic frame_body(input vec_t v, input bit skip_vsa);
    if (!skip_vsa) expect_tok(3'd0, 16'(v.vsa), "R3");
    expect_tok(3'd1, 16'(v.vbp), "R3");
    expect_tok(3'd2, 16'(v.vact), "R3");
    for (int l = 0; l < int'(v.vact); l++) begin
      if (v.pulse) expect_tok(3'd4, v.e_hsa, "R5");
      expect_tok(3'd5, v.e_hbp, "R6");
      expect_tok(3'd6, v.e_hact, "R7");
      expect_tok(3'd7, v.e_hfp, "R5");
    end
    expect_tok(3'd3, 16'(v.vfp), "R3");
  endtask

  task automatic check_idle(input string req);
    repeat (2) @(negedge clk_i);
    check(!tok_valid_o, req, "idle valid", tok_valid_o, 0);
    check(tok_region_o == 3'd3, req, "idle region", tok_region_o, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "R9", "watchdog", 0, 1);
    summary();
  end

  initial begin
    vec_t a, b;
    rst_ni = 1'b0;
    start_i = 1'b0;
    tok_ready_i = 1'b1;
    apply(VECS[0]);
    repeat (3) @(negedge clk_i);
    check(!tok_valid_o, "R1", "valid in reset", tok_valid_o, 0);
    check(tok_region_o == 3'd3, "R1", "region in reset", tok_region_o, 3);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!tok_valid_o, "R1", "valid after reset", tok_valid_o, 0);
    check(tok_region_o == 3'd3, "R1", "region after reset", tok_region_o, 3);

    // table walk: single-frame starts, R9 idle after each
    for (int i = 0; i < 8; i++) begin
      apply(VECS[i]);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      frame_body(VECS[i], 1'b0);
      check_idle("R9");
    end

    // R10 and R9: back-to-back frames, config changed mid-frame; R8 stall
    a = VECS[1];
    b = VECS[1];
    b.hact   = 16'd10;
    b.e_hact = 16'd20;
    apply(a);
    start_i = 1'b1;
    @(negedge clk_i);
    expect_tok(3'd0, 16'(a.vsa), "R3");
    apply(b);
    frame_body(a, 1'b1);            // R10: old HACT kept
    expect_tok(3'd0, 16'(b.vsa), "R9");
    start_i = 1'b0;
    expect_tok(3'd1, 16'(b.vbp), "R3");
    tok_ready_i = 1'b0;             // R8: stall on VACT
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check(tok_valid_o && tok_region_o == 3'd2 && tok_count_o == 16'(b.vact),
            "R8", "held token", tok_region_o, 2);
    end
    tok_ready_i = 1'b1;
    expect_tok(3'd2, 16'(b.vact), "R8");
    expect_tok(3'd4, b.e_hsa, "R5");
    expect_tok(3'd5, b.e_hbp, "R6");
    expect_tok(3'd6, b.e_hact, "R10");
    expect_tok(3'd7, b.e_hfp, "R5");
    expect_tok(3'd3, 16'(b.vfp), "R3");
    check_idle("R9");

    summary();
  end

endmodule